// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit takes one selected bit of an operand, reports that bit's value on the zero flag, and can then leave the bit alone, invert it, clear it or set it. The operand is either a 32-bit register value, which is handled in a single cycle, or one byte in memory. For the byte, the unit reads the byte, changes it and writes it back over a simple request/valid and request/acknowledge handshake. Address generation and instruction decode sit outside the unit.

A caller raises `start_i` for one cycle while `busy_o` is low. The operation code, the bit number, the target select, the register operand and the incoming flag byte are sampled on that edge. `done_o` pulses once when the result and the updated flags are ready. The bit number can come from an immediate or from a register value. Its upper bits are discarded by the wrap rule of the selected target.

Top module: `bit_op_unit`

## Requirements
- R1: `op_i` selects the operation: 0 = test only, 1 = test and invert, 2 = test and clear, 3 = test and set. Only the selected bit of the operand can change.
- R2: The flags are ordered {X,N,Z,V,C} on bits 4..0, so Z is bit 2. `flags_o[2]` is 1 when the selected bit was 0 before any change, and 0 when it was 1.
- R3: With `reg_mem_i`=0 the operand is the 32-bit `reg_data_i` and the bit index is `bit_num_i` modulo 32. `done_o`, `result_o` and `flags_o` are valid on the cycle after the start edge, and no memory request is raised.
- R4: With `reg_mem_i`=1, `mem_rd_req_o` is raised from the cycle after start until the edge on which `mem_rd_valid_i` is high, and the byte on `mem_rd_data_i` is captured on that edge. The bit index is `bit_num_i` modulo 8. For a modifying operation, `mem_wr_req_o` is then held with a stable `mem_wr_data_o` until the edge on which `mem_wr_ack_i` is high. `done_o` follows on the next cycle, with `result_o` equal to the new byte zero-extended.
- R5: The test-only operation never writes. For a register target, `result_o` equals the operand. For a memory target, `mem_wr_req_o` stays low and `done_o` comes on the cycle after the read-valid edge.
- R6: Flag bits X, N, V and C in `flags_o` equal those on `flags_i` at the start edge.
- R7: `start_i` is ignored while `busy_o` is high. It produces no `done_o` and does not alter the running operation.
- R8: `done_o` is high for exactly one cycle per operation, and `mem_rd_req_o` and `mem_wr_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_i | input | 2 | Operation code |
| bit_num_i | input | 8 | Bit number, before wrapping |
| reg_mem_i | input | 1 | Target: 0 register longword, 1 memory byte |
| reg_data_i | input | 32 | Register operand |
| flags_i | input | 5 | Incoming {X,N,Z,V,C} |
| mem_rd_req_o | output | 1 | Byte read request |
| mem_rd_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | 8 | Read byte |
| mem_wr_req_o | output | 1 | Byte write request |
| mem_wr_data_o | output | 8 | Byte to write |
| mem_wr_ack_i | input | 1 | Write accepted |
| busy_o | output | 1 | Memory operation in progress |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 32 | Modified operand |
| flags_o | output | 5 | Updated {X,N,Z,V,C} |

## Verification
The hardest situation to reach is a memory operation held in its read or write wait state while other stimulus arrives. The bench stretches the read-valid and write-acknowledge latencies over several cycles. During those waits it checks that the requests stay up with stable write data, and it fires a register-type start into the wait to show that the start is dropped. Bit numbers of 32 and above are also driven on both target types, so that the two different wrap rules separate on the same input value.

// File: rtl/bit_op_pkg.sv
package bit_op_pkg;
  localparam int FLAG_W = 5;
  localparam int Z_POS  = 2;

  typedef enum logic [1:0] {
    OP_TST = 2'd0,
    OP_CHG = 2'd1,
    OP_CLR = 2'd2,
    OP_SET = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } state_e;
endpackage

// File: rtl/bit_sel_mask.sv
module bit_sel_mask #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int BIDX_W = $clog2(BYTE_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              mem_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < BYTE_W) begin : g_low
      assign mask_o[i] = mem_i ? (idx_i[BIDX_W-1:0] == BIDX_W'(i))
                               : (idx_i == IDX_W'(i));
    end else begin : g_high
      assign mask_o[i] = !mem_i && (idx_i == IDX_W'(i));
    end
  end
endmodule

// File: rtl/bit_modify.sv
module bit_modify
  import bit_op_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] res_o,
  output logic              z_o
);
  assign z_o = ~|(opnd_i & mask_i);

  always_comb begin
    unique case (op_i)
      OP_CHG:  res_o = opnd_i ^ mask_i;
      OP_CLR:  res_o = opnd_i & ~mask_i;
      OP_SET:  res_o = opnd_i | mask_i;
      default: res_o = opnd_i;
    endcase
  end
endmodule

// File: rtl/bit_op_ctrl.sv
module bit_op_ctrl
  import bit_op_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_mem_i,
  input  logic   is_tst_i,
  input  logic   rd_valid_i,
  input  logic   wr_ack_i,
  output state_e state_o,
  output logic   rd_fire_o,
  output logic   wr_fire_o
);
  state_e state_d;

  assign rd_fire_o = (state_o == S_RD) && rd_valid_i;
  assign wr_fire_o = (state_o == S_WR) && wr_ack_i;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      S_IDLE: if (start_mem_i) state_d = S_RD;
      S_RD:   if (rd_valid_i)  state_d = is_tst_i ? S_IDLE : S_WR;
      S_WR:   if (wr_ack_i)    state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= S_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/bit_op_unit.sv
module bit_op_unit
  import bit_op_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int NUM_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [NUM_W-1:0]  bit_num_i,
  input  logic              reg_mem_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              mem_rd_req_o,
  input  logic              mem_rd_valid_i,
  input  logic [BYTE_W-1:0] mem_rd_data_i,
  output logic              mem_wr_req_o,
  output logic [BYTE_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  state_e            state;
  logic              rd_fire, wr_fire, accept, sel_mem;
  op_e               op_q, cur_op;
  logic [IDX_W-1:0]  idx_q, idx_in, cur_idx;
  logic [FLAG_W-1:0] flags_q, cur_flags, new_flags;
  logic [DATA_W-1:0] cur_opnd, mask, res_d, result_q;
  logic              z_d, done_q;

  assign idx_in  = IDX_W'(bit_num_i % NUM_W'(DATA_W));
  assign accept  = start_i && (state == S_IDLE);
  assign sel_mem = (state == S_RD);

  assign cur_op    = sel_mem ? op_q    : op_e'(op_i);
  assign cur_idx   = sel_mem ? idx_q   : idx_in;
  assign cur_flags = sel_mem ? flags_q : flags_i;
  assign cur_opnd  = sel_mem ? DATA_W'(mem_rd_data_i) : reg_data_i;

  always_comb begin
    new_flags        = cur_flags;
    new_flags[Z_POS] = z_d;
  end

  bit_op_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_mem_i (accept && reg_mem_i),
    .is_tst_i    (op_q == OP_TST),
    .rd_valid_i  (mem_rd_valid_i),
    .wr_ack_i    (mem_wr_ack_i),
    .state_o     (state),
    .rd_fire_o   (rd_fire),
    .wr_fire_o   (wr_fire)
  );

  bit_sel_mask #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mask (
    .idx_i  (cur_idx),
    .mem_i  (sel_mem),
    .mask_o (mask)
  );

  bit_modify #(.DATA_W(DATA_W)) u_mod (
    .op_i   (cur_op),
    .opnd_i (cur_opnd),
    .mask_i (mask),
    .res_o  (res_d),
    .z_o    (z_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_TST;
      idx_q    <= '0;
      flags_q  <= '0;
      result_q <= '0;
      flags_o  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q    <= op_e'(op_i);
        idx_q   <= idx_in;
        flags_q <= flags_i;
        if (!reg_mem_i) begin
          result_q <= res_d;
          flags_o  <= new_flags;
          done_q   <= 1'b1;
        end
      end
      if (rd_fire) begin
        result_q <= res_d;
        flags_o  <= new_flags;
        // test-only finishes at read; others wait for write ack
        done_q   <= (op_q == OP_TST);
      end
      if (wr_fire) done_q <= 1'b1;
    end
  end

  assign mem_rd_req_o  = (state == S_RD);
  assign mem_wr_req_o  = (state == S_WR);
  assign mem_wr_data_o = result_q[BYTE_W-1:0];
  assign busy_o        = (state != S_IDLE);
  assign done_o        = done_q;
  assign result_o      = result_q;
endmodule

// File: rtl/bit_op_unit_chk.sv
module bit_op_unit_chk
  import bit_op_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int NUM_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic [NUM_W-1:0]  bit_num_i,
  input logic              reg_mem_i,
  input logic [DATA_W-1:0] reg_data_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              mem_rd_req_o,
  input logic              mem_rd_valid_i,
  input logic              mem_wr_req_o,
  input logic [BYTE_W-1:0] mem_wr_data_o,
  input logic              mem_wr_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic              acc;
  logic              c_mem;
  logic [1:0]        c_op;
  logic [NUM_W-1:0]  c_num;
  logic [DATA_W-1:0] c_data;
  logic [FLAG_W-1:0] c_fl;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_mem <= 1'b0; c_op <= '0; c_num <= '0; c_data <= '0; c_fl <= '0;
    end else if (acc) begin
      c_mem <= reg_mem_i; c_op <= op_i; c_num <= bit_num_i;
      c_data <= reg_data_i; c_fl <= flags_i;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_req_o && mem_wr_req_o)); // R8
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && !mem_rd_valid_i |=> mem_rd_req_o); // R4
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o && !mem_wr_ack_i |=> mem_wr_req_o && $stable(mem_wr_data_o)); // R4
  AST_REG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !reg_mem_i |=> done_o && !mem_rd_req_o); // R3
  AST_TST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && mem_rd_valid_i && c_op == 2'd0 |=> !mem_wr_req_o && done_o); // R5
  AST_FLAGS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[4:3] == c_fl[4:3]) && (flags_o[1:0] == c_fl[1:0])); // R6
  AST_REG_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !c_mem |-> flags_o[Z_POS] == !c_data[c_num % NUM_W'(DATA_W)]); // R2
  AST_BUSY_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !mem_rd_valid_i && !mem_wr_ack_i |=> !done_o); // R7
endmodule

bind bit_op_unit bit_op_unit_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_W(NUM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .bit_num_i(bit_num_i), .reg_mem_i(reg_mem_i), .reg_data_i(reg_data_i),
  .flags_i(flags_i), .mem_rd_req_o(mem_rd_req_o), .mem_rd_valid_i(mem_rd_valid_i),
  .mem_wr_req_o(mem_wr_req_o), .mem_wr_data_o(mem_wr_data_o),
  .mem_wr_ack_i(mem_wr_ack_i), .busy_o(busy_o), .done_o(done_o), .flags_o(flags_o)
);

// File: tb/sim_bit_op_unit.sv
module sim_bit_op_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, reg_mem = 0, rd_valid = 0, wr_ack = 0;
  logic [1:0]  op = 0;
  logic [7:0]  num = 0, rd_data = 0;
  logic [31:0] reg_data = 0;
  logic [4:0]  flags_in = 0;
  logic        rd_req, wr_req, busy, done;
  logic [7:0]  wr_data;
  logic [31:0] result;
  logic [4:0]  flags_out;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_op_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .bit_num_i(num),
    .reg_mem_i(reg_mem), .reg_data_i(reg_data), .flags_i(flags_in),
    .mem_rd_req_o(rd_req), .mem_rd_valid_i(rd_valid), .mem_rd_data_i(rd_data),
    .mem_wr_req_o(wr_req), .mem_wr_data_o(wr_data), .mem_wr_ack_i(wr_ack),
    .busy_o(busy), .done_o(done), .result_o(result), .flags_o(flags_out)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference: returns {z, new_value}
  function automatic logic [32:0] ref_op(int o, int b, logic [31:0] d, bit mem);
    int idx;
    logic [31:0] r;
    idx = mem ? (b % 8) : (b % 32);
    r = d;
    case (o)
      1: r[idx] = ~d[idx];
      2: r[idx] = 1'b0;
      3: r[idx] = 1'b1;
      default: r = d;
    endcase
    return {~d[idx], r};
  endfunction

  function automatic logic [4:0] exp_fl(logic [4:0] f, logic z);
    return {f[4:3], z, f[1:0]};
  endfunction

  // every-clock monitor of handshake exclusion
  always @(negedge clk) if (rst_n) chk("R8", "rd/wr overlap", {30'd0, rd_req, wr_req} == 32'd3, 0);

  task automatic reg_op(int o, int b, logic [31:0] d, logic [4:0] f);
    logic [32:0] e;
    e = ref_op(o, b, d, 0);
    @(negedge clk);
    start = 1; op = 2'(o); num = 8'(b); reg_mem = 0; reg_data = d; flags_in = f;
    @(negedge clk);
    start = 0; reg_data = 32'h5A5A_5A5A; flags_in = ~f;
    chk("R3", "reg done", done, 1);
    chk("R3", "reg no rd_req", rd_req, 0);
    chk("R1", "reg result", result, e[31:0]);
    chk("R2", "reg flags", flags_out, exp_fl(f, e[32]));
    @(negedge clk);
    chk("R8", "done single", done, 0);
  endtask

  task automatic mem_op(int o, int b, logic [7:0] d, logic [4:0] f,
                        int rd_lat, int wr_lat, bit poke);
    logic [32:0] e;
    e = ref_op(o, b, {24'd0, d}, 1);
    @(negedge clk);
    start = 1; op = 2'(o); num = 8'(b); reg_mem = 1; reg_data = 0; flags_in = f;
    @(negedge clk);
    start = 0; flags_in = ~f;
    chk("R4", "rd_req up", rd_req, 1);
    chk("R4", "busy", busy, 1);
    for (int i = 0; i < rd_lat; i++) begin
      if (poke && i == 0) begin
        start = 1; reg_mem = 0; op = 2'd3; reg_data = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      start = 0;
      chk("R4", "rd_req held", rd_req, 1);
      chk("R7", "no done while busy", done, 0);
    end
    rd_valid = 1; rd_data = d;
    @(negedge clk);
    rd_valid = 0; rd_data = 8'hC3;
    chk("R4", "rd_req drop", rd_req, 0);
    if (o == 0) begin
      chk("R5", "tst no write", wr_req, 0);
      chk("R5", "tst done", done, 1);
      chk("R5", "tst result", result, {24'd0, d});
      chk("R2", "tst flags", flags_out, exp_fl(f, e[32]));
    end else begin
      chk("R4", "wr_req up", wr_req, 1);
      chk("R4", "wr data", {24'd0, wr_data}, e[31:0]);
      chk("R4", "no early done", done, 0);
      for (int i = 0; i < wr_lat; i++) begin
        if (poke && i == 0) begin
          start = 1; reg_mem = 0; op = 2'd2;
        end
        @(negedge clk);
        start = 0;
        chk("R4", "wr held", wr_req, 1);
        chk("R4", "wr data stable", {24'd0, wr_data}, e[31:0]);
        chk("R7", "no done while busy", done, 0);
      end
      wr_ack = 1;
      @(negedge clk);
      wr_ack = 0;
      chk("R4", "mem done", done, 1);
      chk("R4", "wr drop", wr_req, 0);
      chk("R1", "mem result", result, e[31:0]);
      chk("R6", "mem flags", flags_out, exp_fl(f, e[32]));
    end
    @(negedge clk);
    chk("R8", "done single", done, 0);
    chk("R7", "idle after", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset done", done, 0);
    chk("R8", "reset rd", rd_req, 0);
    chk("R8", "reset wr", wr_req, 0);
    chk("R7", "reset busy", busy, 0);
    chk("R3", "reset result", result, 0);
    rst_n = 1;
    // register target
    reg_op(0, 7, 32'h0000_0080, 5'b11111);
    reg_op(1, 31, 32'h8000_0001, 5'b10101);
    reg_op(2, 0, 32'hFFFF_FFFF, 5'b01010);
    reg_op(3, 16, 32'h0, 5'b00100);
    reg_op(1, 37, 32'h1234_5678, 5'b11011); // wraps to 5 (R3)
    reg_op(3, 255, 32'h0, 5'b0);            // wraps to 31
    reg_op(0, 3, 32'hFFFF_FFF7, 5'b0);
    // memory target
    mem_op(1, 4, 8'b1010_1010, 5'b11011, 0, 0, 0); // -> 10111010, Z=1
    mem_op(2, 4, 8'b1111_1010, 5'b00100, 2, 1, 0); // -> 11101010, Z=0
    mem_op(3, 13, 8'h00, 5'b10001, 3, 3, 1);       // wraps to 5 (R4)
    mem_op(0, 6, 8'h40, 5'b01110, 1, 0, 1);
    mem_op(0, 41, 8'h00, 5'b10001, 0, 0, 0);       // 41 mod 8 = 1
    mem_op(2, 39, 8'h80, 5'b11111, 4, 2, 0);       // 39 mod 8 = 7
    reg_op(1, 39, 32'h0, 5'b0);                    // 39 mod 32 = 7
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule